// File: doc/BRIEF.md
# Serial MAC Affine Evaluator

This block computes the affine value f = c·x + d of an N-component signed fixed-point point x, with a single multiplier and accumulator that step through the components one per cycle. Upstream logic supplies the point together with a region number. The block reads the coefficient vector c and the offset d of that region from an external synchronous coefficient memory, one word per cycle. It takes N product terms and then adds the offset in a last accumulation step.

The result register is wide enough that no combination of coefficient and input values can overflow or be truncated. The result stays in the scaled domain: any conversion back to physical units by a scalar multiply is done downstream. A parameter picks one of two presentation policies. In the early policy the result appears as soon as the offset is added. In the late policy the finished result is held internally and released at the moment the next point is accepted, so results come out in step with the sampling of new inputs.

Top module: `mac_affine_eval`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0, `res_value` is 0, `coef_rd` is 0 and `in_ready` is 1.
- R2: A point is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for the N+2 cycles that follow an acceptance and returns to 1 after them.
- R3: For the N+1 cycles right after an acceptance, `coef_rd` is 1 and `coef_addr` equals region·2^IW + k, with k counting 0,1,…,N. Index k<N selects coefficient c_k and k=N selects the offset d. IW = ceil(log2(N+1)) is the width of the low index field, and the region occupies the upper bits.
- R4: The memory word on `coef_data` in the cycle after an address is presented is taken as the content of that address.
- R5: The result equals the exact signed sum of c_k·x_k over k<N, plus d, in two's complement with width OW = NBIT + CW + IW. Component x_k is `in_point[k*NBIT +: NBIT]`. All coefficients, the offset and all components are signed.
- R6: With EARLY=1, `res_value` takes the new result on the edge N+2 cycles after the acceptance edge.
- R7: With EARLY=0, a finished result is held back and written to `res_value` on the edge that accepts the next point. The first acceptance after reset writes nothing.
- R8: `res_valid` is 1 for exactly the one cycle after each write to `res_value`. `res_value` does not change at any other time.
- R9: While `in_ready` is 0, `in_valid` and the point inputs have no effect on the coefficient addresses or on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A point is offered |
| in_ready | output | 1 | Block idle, can accept a point |
| in_region | input | RW | Region number for the offered point |
| in_point | input | N_DIM*NBIT | Packed signed components of the point |
| coef_rd | output | 1 | Coefficient memory read strobe |
| coef_addr | output | RW+IW | Coefficient memory address {region, index} |
| coef_data | input | CW | Memory word, one cycle after its address |
| res_valid | output | 1 | Result register was just written |
| res_value | output | OW | Signed result in the scaled domain |

## Verification
In the late policy, the acceptance of a new point and the release of the previous result fall on the same clock edge. On that edge the accumulator is cleared for the new point while the held value moves to the output. The bench provokes this by offering points back to back, with `in_valid` held high. This includes offering a point on the very edge where `in_ready` comes back. A reference model checks every cycle that the released value belongs to the earlier point and that the new point's sum starts from zero. A second instance runs the early policy on the same stimulus, which shows that its result lands exactly N+2 edges after acceptance, whatever new point arrives at the same time.

// File: rtl/mac_eval_pkg.sv
package mac_eval_pkg;

    // Sequencer phases of one evaluation
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_FETCH = 2'd1,
        CS_DRAIN = 2'd2
    } seq_state_e;

endpackage

// File: rtl/mac_eval_seq.sv
module mac_eval_seq
    import mac_eval_pkg::*;
#(
    parameter int N_DIM = 4,
    parameter int RW    = 2,
    parameter int IW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RW-1:0]     in_region,
    output logic              in_ready,
    output logic              accept,
    output logic              coef_rd,
    output logic [RW+IW-1:0]  coef_addr,
    output logic              tap_valid,
    output logic [IW-1:0]     tap_idx,
    output logic              last
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N_DIM);

    typedef struct packed {
        seq_state_e    state;
        logic [IW-1:0] cnt;
        logic [RW-1:0] region;
        logic          tap_v;
        logic [IW-1:0] tap_i;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.tap_v = (seq_q.state == CS_FETCH);
        seq_d.tap_i = seq_q.cnt;
        accept      = in_valid && (seq_q.state == CS_IDLE);
        case (seq_q.state)
            CS_IDLE: begin
                if (accept) begin
                    seq_d.state  = CS_FETCH;
                    seq_d.cnt    = '0;
                    seq_d.region = in_region;
                end
            end
            CS_FETCH: begin
                if (seq_q.cnt == LAST_IDX) seq_d.state = CS_DRAIN;
                else                       seq_d.cnt   = seq_q.cnt + IW'(1);
            end
            default: seq_d.state = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign in_ready  = (seq_q.state == CS_IDLE);
    assign coef_rd   = (seq_q.state == CS_FETCH);
    assign coef_addr = {seq_q.region, seq_q.cnt};
    assign tap_valid = seq_q.tap_v;
    assign tap_idx   = seq_q.tap_i;
    assign last      = seq_q.tap_v && (seq_q.tap_i == LAST_IDX);

    // R3: the first read after acceptance is index 0
    assert_fetch_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept) |-> (coef_rd && coef_addr[IW-1:0] == '0));

    // R3: consecutive reads step the index by one
    assert_fetch_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_rd && $past(coef_rd)) |-> (coef_addr[IW-1:0] == $past(coef_addr[IW-1:0]) + IW'(1)));

    // R2: the block is ready again right after the offset step
    assert_ready_after_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(last) |-> in_ready);

    // R9: no acceptance while reads are in flight
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        coef_rd |=> !$past(accept));

endmodule

// File: rtl/mac_eval_acc.sv
module mac_eval_acc #(
    parameter int N_DIM = 4,
    parameter int NBIT  = 12,
    parameter int CW    = 12,
    parameter int IW    = 3,
    parameter int OW    = 27
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic [N_DIM*NBIT-1:0] in_point,
    input  logic                  tap_valid,
    input  logic [IW-1:0]         tap_idx,
    input  logic [CW-1:0]         coef_data,
    output logic [OW-1:0]         final_sum
);

    localparam int            PW       = NBIT + CW;
    localparam logic [IW-1:0] LAST_IDX = IW'(N_DIM);

    typedef struct packed {
        logic [N_DIM-1:0][NBIT-1:0] pts;
        logic [OW-1:0]              acc;
    } acc_t;

    acc_t acc_d, acc_q;

    logic [NBIT-1:0]        x_sel;
    logic [PW-1:0]          c_ext, x_ext;
    logic signed [PW-1:0]   prod;
    logic [OW-1:0]          term;

    always_comb begin
        x_sel = '0;
        for (int i = 0; i < N_DIM; i++) begin
            if (tap_idx == IW'(i)) x_sel = acc_q.pts[i];
        end
        c_ext = {{NBIT{coef_data[CW-1]}}, coef_data};
        x_ext = {{CW{x_sel[NBIT-1]}}, x_sel};
        prod  = $signed(c_ext) * $signed(x_ext);
        term  = (tap_idx == LAST_IDX) ? {{(OW-CW){coef_data[CW-1]}}, coef_data}
                                      : {{(OW-PW){prod[PW-1]}}, prod};
        final_sum = acc_q.acc + term;

        acc_d = acc_q;
        if (accept) begin
            acc_d.pts = in_point;
            acc_d.acc = '0;
        end else if (tap_valid) begin
            acc_d.acc = final_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R4: data phases only ever carry a valid index
    assert_tap_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tap_valid |-> (tap_idx <= LAST_IDX));

    // R5: a new evaluation starts from an empty accumulator
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept) |-> (acc_q.acc == '0));

endmodule

// File: rtl/mac_eval_out.sv
module mac_eval_out #(
    parameter int OW    = 27,
    parameter bit EARLY = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          last,
    input  logic          accept,
    input  logic [OW-1:0] final_sum,
    output logic          res_valid,
    output logic [OW-1:0] res_value
);

    typedef struct packed {
        logic [OW-1:0] res;
        logic [OW-1:0] hold;
        logic          vld;
        logic          pend;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        if (EARLY) begin
            if (last) begin
                out_d.res = final_sum;
                out_d.vld = 1'b1;
            end
        end else begin
            if (last) begin
                out_d.hold = final_sum;
                out_d.pend = 1'b1;
            end
            if (accept && out_q.pend) begin
                out_d.res  = out_q.hold;
                out_d.vld  = 1'b1;
                out_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_valid = out_q.vld;
    assign res_value = out_q.res;

    generate
        if (EARLY) begin : g_early
            // R6: strobe follows the offset step and nothing else
            assert_early_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid |-> $past(last));
            assert_early_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $past(last) |-> res_valid);
        end else begin : g_late
            // R7: strobe only on an acceptance edge
            assert_late_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid |-> $past(accept));
        end
    endgenerate

    // R8: result is steady between updates
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_value));

endmodule

// File: rtl/mac_affine_eval.sv
module mac_affine_eval #(
    parameter int N_DIM    = 4,
    parameter int NBIT     = 12,
    parameter int CW       = 12,
    parameter int N_REGION = 4,
    parameter bit EARLY    = 1'b1,
    localparam int IW = $clog2(N_DIM + 1),
    localparam int RW = (N_REGION > 1) ? $clog2(N_REGION) : 1,
    localparam int OW = NBIT + CW + IW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [RW-1:0]         in_region,
    input  logic [N_DIM*NBIT-1:0] in_point,
    output logic                  coef_rd,
    output logic [RW+IW-1:0]      coef_addr,
    input  logic [CW-1:0]         coef_data,
    output logic                  res_valid,
    output logic [OW-1:0]         res_value
);

    logic          accept;
    logic          tap_valid;
    logic [IW-1:0] tap_idx;
    logic          last;
    logic [OW-1:0] final_sum;

    mac_eval_seq #(.N_DIM(N_DIM), .RW(RW), .IW(IW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_region (in_region),
        .in_ready  (in_ready),
        .accept    (accept),
        .coef_rd   (coef_rd),
        .coef_addr (coef_addr),
        .tap_valid (tap_valid),
        .tap_idx   (tap_idx),
        .last      (last)
    );

    mac_eval_acc #(.N_DIM(N_DIM), .NBIT(NBIT), .CW(CW), .IW(IW), .OW(OW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .in_point  (in_point),
        .tap_valid (tap_valid),
        .tap_idx   (tap_idx),
        .coef_data (coef_data),
        .final_sum (final_sum)
    );

    mac_eval_out #(.OW(OW), .EARLY(EARLY)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .last      (last),
        .accept    (accept),
        .final_sum (final_sum),
        .res_valid (res_valid),
        .res_value (res_value)
    );

endmodule

// File: tb/tb_mac_affine_eval.sv
`timescale 1ns/1ps
module tb_mac_affine_eval;

    localparam int N  = 4;
    localparam int NB = 12;
    localparam int CW = 12;
    localparam int NR = 4;
    localparam int IW = 3;
    localparam int RW = 2;
    localparam int OW = NB + CW + IW;
    localparam int AW = RW + IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [RW-1:0] in_region = '0;
    logic [N*NB-1:0] in_point = '0;

    logic rdy_a, rdy_l, rd_a, rd_l, vld_a, vld_l;
    logic [AW-1:0] addr_a, addr_l;
    logic [CW-1:0] rom_a = '0, rom_l = '0;
    logic [OW-1:0] res_a, res_l;

    int checks = 0;
    int errors = 0;
    bit fin = 1'b0;

    always #4 clk = ~clk;

    mac_affine_eval #(.N_DIM(N), .NBIT(NB), .CW(CW), .N_REGION(NR), .EARLY(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
        .in_region(in_region), .in_point(in_point), .coef_rd(rd_a),
        .coef_addr(addr_a), .coef_data(rom_a), .res_valid(vld_a), .res_value(res_a));

    mac_affine_eval #(.N_DIM(N), .NBIT(NB), .CW(CW), .N_REGION(NR), .EARLY(1'b0)) dut_l (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_l),
        .in_region(in_region), .in_point(in_point), .coef_rd(rd_l),
        .coef_addr(addr_l), .coef_data(rom_l), .res_valid(vld_l), .res_value(res_l));

    function automatic logic [CW-1:0] rom_word(int a);
        int rg, k, v;
        rg = a >> IW;
        k  = a & ((1 << IW) - 1);
        case (rg)
            0:       v = k * 300 - 700;
            1:       v = 91 - k * 513;
            2:       v = 2047;
            default: v = -2048;
        endcase
        return v[CW-1:0];
    endfunction

    function automatic longint fexp(int rg, logic [N*NB-1:0] p);
        longint s;
        logic [CW-1:0] w;
        logic [NB-1:0] xv;
        s = 0;
        for (int k = 0; k < N; k++) begin
            w  = rom_word(rg * (1 << IW) + k);
            xv = p[k*NB +: NB];
            s  = s + longint'($signed(w)) * longint'($signed(xv));
        end
        w = rom_word(rg * (1 << IW) + N);
        return s + longint'($signed(w));
    endfunction

    // R4: memory answers one cycle after the address
    always @(posedge clk) begin
        rom_a <= rom_word(int'(addr_a));
        rom_l <= rom_word(int'(addr_l));
    end

    // Reference model, advanced on every edge
    int     m_t = 0;
    int     m_reg = 0;
    longint m_val = 0, l_hold = 0, exp_a_res = 0, exp_l_res = 0;
    bit     l_have = 1'b0, exp_a_vld = 1'b0, exp_l_vld = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t <= 0; l_have <= 0; exp_a_vld <= 0; exp_l_vld <= 0;
            exp_a_res <= 0; exp_l_res <= 0;
        end else begin
            exp_a_vld <= 0;
            exp_l_vld <= 0;
            if (in_valid && m_t == 0) begin
                m_t   <= 1;
                m_reg <= int'(in_region);
                m_val <= fexp(int'(in_region), in_point);
                if (l_have) begin
                    exp_l_res <= l_hold;
                    exp_l_vld <= 1;
                    l_have    <= 0;
                end
            end else if (m_t == N + 2) begin
                m_t       <= 0;
                exp_a_res <= m_val;
                exp_a_vld <= 1;
                l_hold    <= m_val;
                l_have    <= 1;
            end else if (m_t > 0) begin
                m_t <= m_t + 1;
            end
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            bit erd;
            int eaddr;
            erd   = (m_t >= 1 && m_t <= N + 1);
            eaddr = m_reg * (1 << IW) + (m_t - 1);
            chk(rdy_a == (m_t == 0), "R2 R9 ready early", rdy_a, m_t == 0);
            chk(rdy_l == (m_t == 0), "R2 R9 ready late", rdy_l, m_t == 0);
            chk(rd_a == erd && rd_l == erd, "R3 read strobe", rd_a, erd);
            if (erd) begin
                chk(int'(addr_a) == eaddr, "R3 address early", addr_a, eaddr);
                chk(int'(addr_l) == eaddr, "R3 address late", addr_l, eaddr);
            end
            chk(vld_a == exp_a_vld, "R6 R8 strobe early", vld_a, exp_a_vld);
            chk(longint'($signed(res_a)) == exp_a_res, "R5 R6 value early",
                longint'($signed(res_a)), exp_a_res);
            chk(vld_l == exp_l_vld, "R7 R8 strobe late", vld_l, exp_l_vld);
            chk(longint'($signed(res_l)) == exp_l_res, "R5 R7 value late",
                longint'($signed(res_l)), exp_l_res);
        end
    end

    task automatic send(int rg, logic [N*NB-1:0] p, int gap);
        @(negedge clk);
        in_valid  = 1'b1;
        in_region = RW'(rg);
        in_point  = p;
        while (!rdy_a) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    function automatic logic [N*NB-1:0] fill(int v);
        logic [N*NB-1:0] p;
        for (int k = 0; k < N; k++) p[k*NB +: NB] = NB'(v);
        return p;
    endfunction

    initial begin
        #(8 * 100000);
        if (!fin) begin
            fin = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk(vld_a == 0 && vld_l == 0, "R1 strobe", vld_a, 0);
        chk(res_a == '0 && res_l == '0, "R1 value", longint'(res_a), 0);
        chk(rd_a == 0 && rd_l == 0, "R1 read", rd_a, 0);
        chk(rdy_a == 1 && rdy_l == 1, "R1 ready", rdy_a, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_a == '0 && vld_a == 0, "R1 after release", longint'(res_a), 0);

        // isolated points, varied gaps and regions
        for (int n = 0; n < 24; n++) begin
            logic [N*NB-1:0] p;
            for (int k = 0; k < N; k++) p[k*NB +: NB] = NB'($urandom);
            send(n % NR, p, n % 4);
        end

        // R9: in_valid held high with inputs changing every cycle
        in_valid = 1'b1;
        for (int n = 0; n < 60; n++) begin
            in_region = RW'($urandom);
            for (int k = 0; k < N; k++) in_point[k*NB +: NB] = NB'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (N + 4) @(negedge clk);

        // R5: extremes of the signed range
        send(3, fill(-2048), 0);
        send(2, fill(2047), 0);
        send(3, fill(2047), 0);
        send(2, fill(-2048), 1);
        send(0, fill(0), 2);
        send(1, fill(-1), 0);
        send(0, fill(1), 0);
        repeat (N + 6) @(negedge clk);

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule